// File: doc/BRIEF.md
# Quadrature Encoder Emulation Generator

This block turns a tracked absolute angle word into the signals of an incremental optical encoder. It drives two square-wave channels 90 degrees apart, a once-per-revolution marker and a direction flag. A motor controller that expects an encoder can therefore work from the tracked angle with no disc fitted. The line count follows a two-bit resolution select. One angle step at the selected resolution produces exactly one edge on one of the two channels.

Internally the block keeps the count it has already issued. On each clock where the valid flag is high, it moves that count one step toward the incoming angle. The step goes the shorter way round the circle. A jump of many steps is therefore replayed as a burst of single steps, one per clock, so a downstream counter loses nothing. While valid is low everything freezes. When valid returns, the block catches up from where it stopped.

Top module: `qenc_emulator`

## Requirements
- R1: While reset is high, and in the cycle after it, the issued count is zero. A=1, B=1, marker=1 and DIR=1.
- R2: The resolution select picks 10, 12, 14 or 16 bits for the codes 0, 1, 2 and 3. The count at that resolution is the top bits of the 16-bit angle, so one step is 2^6, 2^4, 2^2 or 2^0 angle units.
- R3: The quadrature state is set by the issued count modulo 4 at the selected resolution. The values 0, 1, 2 and 3 give (A,B) = 11, 10, 00 and 01.
- R4: On a clock edge with valid high, the issued count moves one step toward the masked angle input. The outputs show the new count after that edge.
- R5: A gap of several steps is covered at one step per clock. With the resolution unchanged, at most one of A and B changes between two clock edges.
- R6: The step goes the shorter way round the circle. A gap of exactly half a revolution steps backward. DIR goes to 1 on a forward step and to 0 on a backward step, and it holds when no step is taken.
- R7: The marker is 1 exactly when the issued count at the selected resolution is zero. A and B are both 1 whenever the marker is 1.
- R8: While valid is low the count, A, B, marker and DIR hold. After valid rises again the block resumes stepping from the held count.
- R9: Counting wraps at a full revolution in both directions. Crossing zero gives exactly one marker cycle per crossing.
- R10: When the resolution changes, the finer bits of the issued count are dropped. Stepping continues from the truncated count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| angle_i | input | ANGLE_W | Tracked absolute angle, full scale is one revolution |
| res_sel_i | input | 2 | Resolution code: 0=10, 1=12, 2=14, 3=16 bits |
| valid_i | input | 1 | High while the resolver signals are valid |
| enc_a_o | output | 1 | Quadrature channel A |
| enc_b_o | output | 1 | Quadrature channel B |
| mark_o | output | 1 | Once-per-revolution marker |
| dir_o | output | 1 | 1 while stepping forward, 0 while stepping backward |

## Verification
The bench builds the block with the default 16-bit angle word. This makes all four resolution codes reachable and keeps a half-revolution gap at 32768 fine steps, so the backward tie can be tested in a single step. At the 10- and 12-bit settings a full wrap through zero takes only a few hundred or a few thousand clocks. The bench therefore drives real zero crossings in both directions and counts the marker pulses. Random runs that mix angle jumps, valid drop-outs and resolution changes are compared cycle by cycle against a step model in the bench.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // number of resolution codes and bit span between coarsest and finest
    localparam int MODE_COUNT = 4;
    localparam int RES_SPAN   = 6;

    typedef enum logic [1:0] {
        RES_COARSE = 2'd0,
        RES_MID    = 2'd1,
        RES_FINE   = 2'd2,
        RES_FULL   = 2'd3
    } res_mode_e;

    typedef enum logic [1:0] {
        MOVE_HOLD = 2'd0,
        MOVE_UP   = 2'd1,
        MOVE_DOWN = 2'd2
    } move_e;

    typedef struct packed {
        logic a;
        logic b;
    } quad_t;

    // phase 0 is the marker-aligned state; each phase step flips one channel
    function automatic quad_t phase_to_quad(input logic [1:0] ph);
        quad_t q;
        case (ph)
            2'd0:    q = '{a: 1'b1, b: 1'b1};
            2'd1:    q = '{a: 1'b1, b: 1'b0};
            2'd2:    q = '{a: 1'b0, b: 1'b0};
            default: q = '{a: 1'b0, b: 1'b1};
        endcase
        return q;
    endfunction

endpackage

// File: rtl/qenc_res_decode.sv
module qenc_res_decode
    import qenc_pkg::*;
#(
    parameter int ANGLE_W = 16,
    parameter int SHW     = $clog2(ANGLE_W)
) (
    input  res_mode_e            mode_i,
    output logic [ANGLE_W-1:0]   step_o,
    output logic [ANGLE_W-1:0]   keep_o,
    output logic [SHW-1:0]       drop_o
);

    logic [ANGLE_W-1:0] step_tab [MODE_COUNT];
    logic [ANGLE_W-1:0] keep_tab [MODE_COUNT];
    logic [SHW-1:0]     drop_tab [MODE_COUNT];

    // one constant entry per resolution code: coarser codes drop more bits
    for (genvar g = 0; g < MODE_COUNT; g++) begin : g_mode
        localparam int DROP = RES_SPAN - 2 * g;
        localparam logic [ANGLE_W-1:0] STEP = ANGLE_W'(1) << DROP;
        localparam logic [ANGLE_W-1:0] KEEP = ~(STEP - ANGLE_W'(1));
        assign step_tab[g] = STEP;
        assign keep_tab[g] = KEEP;
        assign drop_tab[g] = SHW'(DROP);
    end

    always_comb begin
        step_o = step_tab[mode_i];
        keep_o = keep_tab[mode_i];
        drop_o = drop_tab[mode_i];
    end

endmodule

// File: rtl/qenc_track.sv
module qenc_track
    import qenc_pkg::*;
#(
    parameter int ANGLE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic [ANGLE_W-1:0] target_i,
    input  logic [ANGLE_W-1:0] step_i,
    input  logic [ANGLE_W-1:0] keep_i,
    output logic [ANGLE_W-1:0] cnt_o,
    output logic               dir_o
);

    logic [ANGLE_W-1:0] cur;
    logic [ANGLE_W-1:0] tgt;
    logic [ANGLE_W-1:0] gap;
    move_e              move;

    // the gap is read modulo one revolution; its top bit picks the short way
    always_comb begin
        cur = cnt_o & keep_i;
        tgt = target_i & keep_i;
        gap = tgt - cur;
        if (gap == '0)
            move = MOVE_HOLD;
        else if (!gap[ANGLE_W-1])
            move = MOVE_UP;
        else
            move = MOVE_DOWN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            dir_o <= 1'b1;
        end else if (valid_i) begin
            case (move)
                MOVE_UP: begin
                    cnt_o <= cur + step_i;
                    dir_o <= 1'b1;
                end
                MOVE_DOWN: begin
                    cnt_o <= cur - step_i;
                    dir_o <= 1'b0;
                end
                default: cnt_o <= cur;
            endcase
        end
    end

    // R8
    hold_when_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(cnt_o) && $stable(dir_o)));

    // R6
    dir_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(cnt_o) |-> $stable(dir_o));

endmodule

// File: rtl/qenc_phase.sv
module qenc_phase
    import qenc_pkg::*;
#(
    parameter int ANGLE_W = 16,
    parameter int SHW     = $clog2(ANGLE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ANGLE_W-1:0] cnt_i,
    input  logic [ANGLE_W-1:0] keep_i,
    input  logic [SHW-1:0]     drop_i,
    output logic               a_o,
    output logic               b_o,
    output logic               mark_o
);

    logic [ANGLE_W-1:0] masked;
    logic [ANGLE_W-1:0] pos;
    quad_t              q;

    always_comb begin
        masked = cnt_i & keep_i;
        pos    = masked >> drop_i;
        q      = phase_to_quad(pos[1:0]);
        a_o    = q.a;
        b_o    = q.b;
        mark_o = (masked == '0);
    end

    // R5
    one_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(drop_i) |-> ($countones({a_o ^ $past(a_o), b_o ^ $past(b_o)}) <= 1));

    // R7
    mark_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        mark_o |-> (a_o && b_o));

endmodule

// File: rtl/qenc_emulator.sv
module qenc_emulator
    import qenc_pkg::*;
#(
    parameter int ANGLE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic [1:0]         res_sel_i,
    input  logic               valid_i,
    output logic               enc_a_o,
    output logic               enc_b_o,
    output logic               mark_o,
    output logic               dir_o
);

    localparam int SHW = $clog2(ANGLE_W);

    res_mode_e          mode;
    logic [ANGLE_W-1:0] step;
    logic [ANGLE_W-1:0] keep;
    logic [SHW-1:0]     drop;
    logic [ANGLE_W-1:0] cnt;

    assign mode = res_mode_e'(res_sel_i);

    qenc_res_decode #(.ANGLE_W(ANGLE_W), .SHW(SHW)) u_decode (
        .mode_i (mode),
        .step_o (step),
        .keep_o (keep),
        .drop_o (drop)
    );

    qenc_track #(.ANGLE_W(ANGLE_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (valid_i),
        .target_i (angle_i),
        .step_i   (step),
        .keep_i   (keep),
        .cnt_o    (cnt),
        .dir_o    (dir_o)
    );

    qenc_phase #(.ANGLE_W(ANGLE_W), .SHW(SHW)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .cnt_i  (cnt),
        .keep_i (keep),
        .drop_i (drop),
        .a_o    (enc_a_o),
        .b_o    (enc_b_o),
        .mark_o (mark_o)
    );

endmodule

// File: tb/qenc_emulator_test.sv
module qenc_emulator_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] angle = '0;
    logic [1:0]  sel = 2'd3;
    logic        valid = 1'b1;
    logic        enc_a, enc_b, mark, dir;

    int errors = 0;
    int checks = 0;
    int e_m = 0;
    bit dir_m = 1'b1;
    bit done = 1'b0;
    int prev_s = 3;
    int prev_ab = 3;
    int marks = 0;
    int edges = 0;
    int snap = 0;
    int ang = 0;
    int s_r = 3;

    always #10 clk = ~clk;

    qenc_emulator uut (
        .clk       (clk),
        .rst       (rst),
        .angle_i   (angle),
        .res_sel_i (sel),
        .valid_i   (valid),
        .enc_a_o   (enc_a),
        .enc_b_o   (enc_b),
        .mark_o    (mark),
        .dir_o     (dir)
    );

    function automatic int drop_of(int s);
        return 6 - 2 * s;
    endfunction

    function automatic int keep_of(int s);
        return 32'hFFFF & ~((1 << drop_of(s)) - 1);
    endfunction

    function automatic int exp_outs(int s);
        int m, ph, a, b, nm;
        m  = e_m & keep_of(s);
        ph = (m >> drop_of(s)) & 3;
        a  = (ph < 2) ? 1 : 0;
        b  = (ph == 0 || ph == 3) ? 1 : 0;
        nm = (m == 0) ? 1 : 0;
        return (a << 3) | (b << 2) | (nm << 1) | int'(dir_m);
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic model_step(input int a_in, input int s);
        int cur, tgt, gap, st;
        st  = 1 << drop_of(s);
        cur = e_m & keep_of(s);
        tgt = a_in & keep_of(s);
        gap = (tgt - cur) & 32'hFFFF;
        if (gap == 0) begin
            e_m = cur;
        end else if (gap < 32768) begin
            e_m = (cur + st) & 32'hFFFF;
            dir_m = 1'b1;
        end else begin
            e_m = (cur - st) & 32'hFFFF;
            dir_m = 1'b0;
        end
    endtask

    function automatic int outs_now();
        return 32'({enc_a, enc_b, mark, dir});
    endfunction

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cycle(input int a_in, input int s, input bit v, input string req);
        int ab;
        angle = a_in[15:0];
        sel   = s[1:0];
        valid = v;
        @(posedge clk);
        if (v) model_step(a_in, s);
        @(negedge clk);
        check(req, outs_now(), exp_outs(s));
        ab = 32'({enc_a, enc_b});
        if (s == prev_s)
            check("R5", (((ab ^ prev_ab) == 3) ? 1 : 0), 0);
        if (ab != prev_ab) edges++;
        if (mark) marks++;
        prev_ab = ab;
        prev_s  = s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4021));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", outs_now(), 4'b1111);
        rst = 1'b0;
        cycle(0, 3, 1'b1, "R1");

        // R4 single forward steps at 16 bits
        for (int i = 1; i <= 8; i++) cycle(i, 3, 1'b1, "R4");
        check("R6", 32'(dir), 1);
        // R3 backward phase sequence
        for (int i = 7; i >= 0; i--) cycle(i, 3, 1'b1, "R3");
        check("R6", 32'(dir), 0);

        // R5 catch-up of five coarse steps at 10 bits
        edges = 0;
        for (int i = 0; i < 7; i++) cycle(5 << 6, 0, 1'b1, "R5");
        check("R5", edges, 5);
        for (int i = 0; i < 6; i++) cycle(0, 0, 1'b1, "R5");

        // R6 half-revolution tie steps backward
        cycle(16'h8000, 3, 1'b1, "R6");
        check("R6", 32'({dir, mark}), 0);
        cycle(0, 3, 1'b1, "R6");
        check("R7", 32'(mark), 1);

        // R8 hold while invalid, then resume
        snap = outs_now();
        for (int i = 0; i < 5; i++) cycle(16'h4000, 0, 1'b0, "R8");
        check("R8", outs_now(), snap);
        for (int i = 0; i < 260; i++) cycle(16'h4000, 0, 1'b1, "R8");

        // R9 backward wrap through zero at 12 bits
        marks = 0;
        for (int i = 0; i < 1030; i++) cycle(16'hFFE0, 1, 1'b1, "R9");
        check("R9", marks, 1);
        marks = 0;
        for (int i = 0; i < 7; i++) cycle(16'h0030, 1, 1'b1, "R9");
        check("R9", marks, 1);
        check("R6", 32'(dir), 1);

        // R10 truncation on resolution change
        for (int i = 0; i < 7; i++) cycle(16'h0035, 3, 1'b1, "R10");
        cycle(16'h0035, 0, 1'b1, "R10");
        check("R10", 32'(mark), 1);

        // R2 step size at 14 bits: 16 units is four steps
        edges = 0;
        for (int i = 0; i < 6; i++) cycle(16'h0010, 2, 1'b1, "R2");
        check("R2", edges, 4);

        // random mix of motion, drop-outs and resolution changes
        ang = 16'h0010;
        s_r = 2;
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 999));
            if (r < 5) s_r = int'($urandom_range(0, 3));
            if (r < 20) ang = int'($urandom_range(0, 65535));
            else ang = (ang + int'($urandom_range(0, 400)) - 200) & 32'hFFFF;
            cycle(ang, s_r, ($urandom_range(0, 9) != 0), "R4");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule